// File: doc/BRIEF.md
# Performance Event Counter Bank

A bank of wide hardware event counters that sits beside a processor core. Each counter slot receives a single-cycle event pulse from the core and adds one to its count when counting is allowed. Counting is allowed only when the global control register enables it, the current privilege level of the core is enabled in that register, and the slot's count-enable bit is set. Each counter is wider than the 32-bit register port, so software reaches it as two registers, one for the low word and one for the high bits. Software typically reads the high word, then the low word, then the high word again, and repeats until both high reads agree. The block therefore never freezes a counter for a read: the low word keeps counting between the reads.

When a counter passes its all-ones value it wraps to zero and latches a bit in an overflow status register. A single interrupt line is raised while any status bit is set whose interrupt-enable bit is also set. To sample every N events, software loads the two's complement of N, masked to the counter width. Software clears status bits by writing zeros to them. A write of the control register can also clear every counter, every status bit, or both, in the cycle of the write.

The register port is a request channel and a read-response channel, both valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Writes produce no response. An accepted read puts its data in a one-entry response register in the next cycle. The response stays valid and unchanged until `rsp_ready` is seen high. While a response is held and `rsp_ready` is low, `req_ready` is low and no request is taken.

Top module: `pmc_bank`

## Requirements
- R1: After reset, every counter, the control register, both mask registers and the status register read as zero, `irq_o` is low, `rsp_valid` is low and `req_ready` is high.
- R2: Counter i occupies address 2i for bits 31:0 and address 2i+1 for its bits above 31. The upper read is zero-extended, and a write to either address loads only that part of the counter. The control register is at 0x40, count-enable at 0x41, interrupt-enable at 0x42 and overflow status at 0x43, with bit i of each mask belonging to counter i.
- R3: A counter adds one at each clock edge where its event input is high, its count-enable bit is set, control bits 0 and 1 are both set, and the mode bit for the current level is set. Bit 2 is the mode bit when `core_priv` is 1 and bit 3 is the mode bit when `core_priv` is 0. Otherwise the counter holds its value.
- R4: With the control register holding 0x2 (bit 1 alone), no counter changes whatever the event inputs do.
- R5: A read returns the counter value at the cycle the read is accepted. No snapshot is taken, so events between the high and low reads are visible in the low word, and a carry out of the low word shows in the high word.
- R6: A counter at all-ones that counts wraps to zero and sets its status bit. Loading the two's complement of N makes the wrap happen on the N-th counted event.
- R7: A write to the status register clears the bits written as 0 and leaves the bits written as 1 unchanged. A wrap in the same cycle as any clear leaves its bit set.
- R8: `irq_o` is high exactly while some status bit and the matching interrupt-enable bit are both set.
- R9: A control write with bit 31 set clears all counters, and one with bit 30 set clears all status bits, both at the edge that takes the write. Bits 31 and 30 are not stored, while bits 3:0 of the same write are stored and read back.
- R10: A read response stays valid with unchanged data until accepted. While it is held with `rsp_ready` low, `req_ready` is low.
- R11: A write to a counter in the same cycle as a counted event loads the written value, and that event is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Register request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Read data taken by the requester |
| rsp_rdata | output | 32 | Read data |
| core_priv | input | 1 | 1 = core in privileged mode, 0 = user mode |
| event_i | input | NUM_CNT | One event pulse per counter slot |
| irq_o | output | 1 | Shared overflow interrupt |

## Verification
Several properties are checked by assertions on every cycle. A counter with no event, write or clear holds its value. An all-ones counter that counts reads zero on the next cycle. Status bits never drop without a status write or a clear command. A held read response keeps its data. Other behaviours can only be shown by the bench's scenarios. These include the privilege-mode filter, the stopped-control encoding, the split address map with a carry across halves, the live low word between two high reads, the same-cycle priorities of a wrap against a status clear and of a write against an event, and the gating of the interrupt by its enable mask.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 7'h40;
  localparam logic [ADDR_W-1:0] A_CEN  = 7'h41;
  localparam logic [ADDR_W-1:0] A_IEN  = 7'h42;
  localparam logic [ADDR_W-1:0] A_OVF  = 7'h43;

  localparam int CB_RUN   = 0;
  localparam int CB_GATE  = 1;
  localparam int CB_PRIV  = 2;
  localparam int CB_USER  = 3;
  localparam int CB_CLRST = 30;
  localparam int CB_CLRCT = 31;
  localparam int CTL_W    = 4;

  typedef struct packed {
    logic wr_ctl;
    logic wr_cen;
    logic wr_ien;
    logic wr_ovf;
  } reg_wr_t;
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int W = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inc,
  input  logic        clr,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output logic [W-1:0] cnt,
  output logic        wrap
);
  localparam int HI_W = W - 32;

  logic at_max;
  assign at_max = (cnt == {W{1'b1}});
  assign wrap   = inc && at_max && !clr && !wr_lo && !wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cnt[31:0] <= wdata;
      if (wr_hi) cnt[W-1:32] <= wdata[HI_W-1:0];
    end else if (inc) begin
      cnt <= cnt + W'(1);
    end
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr && !wr_lo && !wr_hi) |=> $stable(cnt));

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && (cnt == {W{1'b1}}) && !clr && !wr_lo && !wr_hi) |=> (cnt == '0));
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl import pmc_pkg::*; #(
  parameter int NUM_CNT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  reg_wr_t            wr,
  input  logic [31:0]        wdata,
  input  logic               core_priv,
  input  logic [NUM_CNT-1:0] wrap,
  output logic [CTL_W-1:0]   ctl_q,
  output logic [NUM_CNT-1:0] cen_q,
  output logic [NUM_CNT-1:0] ien_q,
  output logic [NUM_CNT-1:0] ovf_q,
  output logic               count_ok,
  output logic               clr_cnt,
  output logic               irq_o
);
  logic clr_ovf;
  logic mode_ok;
  logic [NUM_CNT-1:0] ovf_d;

  assign clr_cnt = wr.wr_ctl && wdata[CB_CLRCT];
  assign clr_ovf = wr.wr_ctl && wdata[CB_CLRST];

  assign mode_ok  = core_priv ? ctl_q[CB_PRIV] : ctl_q[CB_USER];
  assign count_ok = ctl_q[CB_RUN] && ctl_q[CB_GATE] && mode_ok;

  always_comb begin
    ovf_d = ovf_q;
    if (clr_ovf)        ovf_d = '0;
    else if (wr.wr_ovf) ovf_d = ovf_q & wdata[NUM_CNT-1:0];
    ovf_d = ovf_d | wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cen_q <= '0;
      ien_q <= '0;
      ovf_q <= '0;
    end else begin
      if (wr.wr_ctl) ctl_q <= wdata[CTL_W-1:0];
      if (wr.wr_cen) cen_q <= wdata[NUM_CNT-1:0];
      if (wr.wr_ien) ien_q <= wdata[NUM_CNT-1:0];
      ovf_q <= ovf_d;
    end
  end

  assign irq_o = |(ovf_q & ien_q);

  // R7
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr.wr_ovf && !clr_ovf) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && (wrap == '0)) |=> (ovf_q == '0));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq_o);
endmodule

// File: rtl/pmc_rdmux.sv
module pmc_rdmux import pmc_pkg::*; #(
  parameter int NUM_CNT = 32,
  parameter int CNT_W   = 48
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt,
  input  logic [CTL_W-1:0]               ctl,
  input  logic [NUM_CNT-1:0]             cen,
  input  logic [NUM_CNT-1:0]             ien,
  input  logic [NUM_CNT-1:0]             ovf,
  output logic [31:0]                    rdata
);
  always_comb begin
    rdata = '0;
    if (!addr[ADDR_W-1]) begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (addr[5:1] == 5'(i)) begin
          rdata = addr[0] ? 32'(cnt[i][CNT_W-1:32]) : cnt[i][31:0];
        end
      end
    end else begin
      case (addr)
        A_CTRL:  rdata = 32'(ctl);
        A_CEN:   rdata = 32'(cen);
        A_IEN:   rdata = 32'(ien);
        A_OVF:   rdata = 32'(ovf);
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank import pmc_pkg::*; #(
  parameter int NUM_CNT = 32,
  parameter int CNT_W   = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [6:0]         req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_rdata,
  input  logic               core_priv,
  input  logic [NUM_CNT-1:0] event_i,
  output logic               irq_o
);
  logic acc, acc_wr;
  reg_wr_t wr;
  logic [CTL_W-1:0]             ctl_q;
  logic [NUM_CNT-1:0]           cen_q, ien_q, ovf_q, wrap_vec;
  logic                         count_ok, clr_cnt;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_arr;
  logic [31:0]                  rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign acc_wr    = acc && req_write;

  assign wr.wr_ctl = acc_wr && (req_addr == A_CTRL);
  assign wr.wr_cen = acc_wr && (req_addr == A_CEN);
  assign wr.wr_ien = acc_wr && (req_addr == A_IEN);
  assign wr.wr_ovf = acc_wr && (req_addr == A_OVF);

  pmc_ctrl #(.NUM_CNT(NUM_CNT)) u_ctrl (
    .clk, .rst_n, .wr, .wdata(req_wdata), .core_priv, .wrap(wrap_vec),
    .ctl_q, .cen_q, .ien_q, .ovf_q, .count_ok, .clr_cnt, .irq_o
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_slot
    logic hit;
    assign hit = acc_wr && !req_addr[6] && (req_addr[5:1] == 5'(g));
    pmc_counter #(.W(CNT_W)) u_slot (
      .clk, .rst_n,
      .inc   (count_ok && cen_q[g] && event_i[g]),
      .clr   (clr_cnt),
      .wr_lo (hit && !req_addr[0]),
      .wr_hi (hit && req_addr[0]),
      .wdata (req_wdata),
      .cnt   (cnt_arr[g]),
      .wrap  (wrap_vec[g])
    );
  end

  pmc_rdmux #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_rdmux (
    .addr(req_addr), .cnt(cnt_arr), .ctl(ctl_q), .cen(cen_q),
    .ien(ien_q), .ovf(ovf_q), .rdata(rd_mux)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: tb/pmc_bank_tb.sv
`timescale 1ns/1ps
module pmc_bank_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1, core_priv = 1'b1;
  logic [6:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] ev = '0;
  logic req_ready, rsp_valid, irq_o;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  pmc_bank u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_rdata, .core_priv, .event_i(ev), .irq_o
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_reg(input logic [6:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ev = '0; ev[idx] = 1'b1;
      @(negedge clk); ev = '0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10: got %h expected no response", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          errors++;
          $display("FAIL %s: got %h expected %h", t, rsp_rdata, e);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(irq_o == 1'b0, "R1", 32'(irq_o), 0);
    chk(req_ready == 1'b1, "R1", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", 32'(rsp_valid), 0);
    rd_reg(7'h40, 0, "R1");
    rd_reg(7'h41, 0, "R1");
    rd_reg(7'h43, 0, "R1");
    rd_reg(7'h0A, 0, "R1");
    rd_reg(7'h0B, 0, "R1");

    // R2 split halves
    wr_reg(7'h06, 32'h1234_5678);
    wr_reg(7'h07, 32'hFFFF_ABCD);
    rd_reg(7'h06, 32'h1234_5678, "R2");
    rd_reg(7'h07, 32'h0000_ABCD, "R2");
    rd_reg(7'h04, 0, "R2");

    // R3 gating and mode filter
    wr_reg(7'h41, 32'h8);
    wr_reg(7'h40, 32'hF);
    core_priv = 1'b1;
    pulse(3, 5);
    rd_reg(7'h06, 32'h1234_567D, "R3");
    pulse(2, 3);
    rd_reg(7'h04, 0, "R3");
    wr_reg(7'h40, 32'h7);
    core_priv = 1'b0;
    pulse(3, 4);
    rd_reg(7'h06, 32'h1234_567D, "R3");
    core_priv = 1'b1;
    pulse(3, 2);
    rd_reg(7'h06, 32'h1234_567F, "R3");
    wr_reg(7'h40, 32'hB);
    core_priv = 1'b0;
    pulse(3, 1);
    rd_reg(7'h06, 32'h1234_5680, "R3");
    wr_reg(7'h40, 32'hD);
    pulse(3, 2);
    rd_reg(7'h06, 32'h1234_5680, "R3");

    // R4 stopped encoding
    wr_reg(7'h40, 32'h2);
    core_priv = 1'b1;
    pulse(3, 3);
    rd_reg(7'h06, 32'h1234_5680, "R4");

    // R5 live low word and carry
    wr_reg(7'h40, 32'hF);
    rd_reg(7'h07, 32'h0000_ABCD, "R5");
    pulse(3, 2);
    rd_reg(7'h06, 32'h1234_5682, "R5");
    rd_reg(7'h07, 32'h0000_ABCD, "R5");
    wr_reg(7'h06, 32'hFFFF_FFFF);
    pulse(3, 1);
    rd_reg(7'h06, 0, "R5");
    rd_reg(7'h07, 32'h0000_ABCE, "R5");

    // R6 wrap after a period of 2
    wr_reg(7'h01, 32'h0000_FFFF);
    wr_reg(7'h00, 32'hFFFF_FFFE);
    wr_reg(7'h41, 32'h9);
    pulse(0, 1);
    rd_reg(7'h43, 0, "R6");
    pulse(0, 1);
    rd_reg(7'h00, 0, "R6");
    rd_reg(7'h01, 0, "R6");
    rd_reg(7'h43, 1, "R6");
    @(negedge clk);
    chk(irq_o == 1'b0, "R8", 32'(irq_o), 0);

    // R8 interrupt gating
    wr_reg(7'h42, 32'h1);
    chk(irq_o == 1'b1, "R8", 32'(irq_o), 1);
    wr_reg(7'h42, 32'h0);
    chk(irq_o == 1'b0, "R8", 32'(irq_o), 0);
    wr_reg(7'h42, 32'h1);

    // R7 write-zero-to-clear
    wr_reg(7'h43, 32'h1);
    rd_reg(7'h43, 1, "R7");
    chk(irq_o == 1'b1, "R7", 32'(irq_o), 1);
    wr_reg(7'h43, 32'hFFFF_FFFE);
    rd_reg(7'h43, 0, "R7");
    chk(irq_o == 1'b0, "R7", 32'(irq_o), 0);
    wr_reg(7'h00, 32'hFFFF_FFFF);
    wr_reg(7'h01, 32'h0000_FFFF);
    @(negedge clk);
    ev = '0; ev[0] = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 7'h43; req_wdata = 0;
    @(negedge clk);
    ev = '0; req_valid = 1'b0; req_write = 1'b0;
    rd_reg(7'h43, 1, "R7");
    rd_reg(7'h00, 0, "R7");

    // R9 clear commands
    wr_reg(7'h40, 32'h4000_000F);
    rd_reg(7'h43, 0, "R9");
    rd_reg(7'h07, 32'h0000_ABCE, "R9");
    rd_reg(7'h40, 32'hF, "R9");
    wr_reg(7'h40, 32'hC000_0002);
    rd_reg(7'h40, 32'h2, "R9");
    rd_reg(7'h07, 0, "R9");
    rd_reg(7'h43, 0, "R9");

    // R11 write beats event
    wr_reg(7'h40, 32'hF);
    @(negedge clk);
    ev = '0; ev[3] = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 7'h06; req_wdata = 32'h55;
    @(negedge clk);
    ev = '0; req_valid = 1'b0; req_write = 1'b0;
    rd_reg(7'h06, 32'h55, "R11");
    pulse(3, 1);
    rd_reg(7'h06, 32'h56, "R11");

    // R10 response back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    exp_q.push_back(32'h56); tag_q.push_back("R10");
    req_valid = 1'b1; req_write = 1'b0; req_addr = 7'h06;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R10", 32'(rsp_valid), 1);
    chk(req_ready == 1'b0, "R10", 32'(req_ready), 0);
    held = rsp_rdata;
    repeat (2) @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_rdata == held, "R10", rsp_rdata, held);
    chk(req_ready == 1'b0, "R10", 32'(req_ready), 0);
    @(posedge clk);
    #2 rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10", 32'(exp_q.size()), 0);
    chk(rsp_valid == 1'b0, "R10", 32'(rsp_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule